// File: doc/BRIEF.md
# Pipeline Forwarding and Load-Use Interlock

This block is the hazard controller of a five-stage in-order pipeline: fetch, decode with register read, execute, memory access and writeback. Each cycle it compares the source register numbers of the instruction in decode with the destination numbers, write enables and load flags of the instructions further down the pipe. From these it produces three things: the operand bypass selects for the execute stage, a stall that freezes the PC and the fetch/decode register, and a bubble request that loads a no-op into the decode/execute register.

The block keeps its own registered copy of the decode sources as they move into execute. The bypass selects therefore refer to the instruction that is in execute right now, and they are compared against the memory and writeback stages. An ALU result reaches a dependent instruction one or two instructions behind it through the bypass. A consumer three instructions behind its producer needs no bypass, because the register file is written in the first half of the cycle and read in the second. A load followed at once by a user of its result costs one bubble cycle, and the loaded data then comes through the writeback bypass.

Top module: `hazard_ctrl`

## Requirements
- R1: While reset is asserted and right after it, both bypass selects are 00 and stall and bubble are low.
- R2: When the instruction in execute reads a nonzero register that the memory-stage instruction writes (write enable high), that operand's select is 01. This takes effect one clock after the consumer was in decode.
- R3: When the execute instruction reads a nonzero register that only the writeback-stage instruction writes, that operand's select is 10.
- R4: When both the memory-stage and the writeback-stage instructions write the register being read, the select is 01, so the newer result wins.
- R5: When the producer has already left writeback, or no later stage writes the register, the select is 00 and the register file value is used.
- R6: Register 0 never yields a nonzero select and never causes a stall.
- R7: When the execute instruction is a load with write enable high and a nonzero destination, and that destination equals either decode source, stall and bubble are both high in that same cycle.
- R8: In the cycle after a stall, execute holds the bubble and both selects are 00. The held consumer then reaches execute with select 10 for the loaded register.
- R9: A load whose destination no decode source uses causes no stall, and an instruction that is not a load never causes a stall.
- R10: A stage whose write enable is low is never a bypass source and never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_rs1_i | input | AW | First source register of the decode instruction |
| id_rs2_i | input | AW | Second source register of the decode instruction |
| ex_rd_i | input | AW | Destination of the execute instruction |
| ex_we_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | AW | Destination of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | AW | Destination of the writeback-stage instruction |
| wb_we_i | input | 1 | Writeback-stage instruction writes a register |
| fwd_a_o | output | 2 | First operand select: 00 register file, 01 memory ALU result, 10 writeback value |
| fwd_b_o | output | 2 | Second operand select, same encoding |
| stall_o | output | 1 | Hold the PC and the fetch/decode register |
| bubble_o | output | 1 | Load a no-op into decode/execute |

## Verification
If the registered copy of the sources holds the wrong value, the wrong select shows up on the very next cycle and stays for as long as that instruction sits in execute. This happens, for example, when the copy is not cleared on a bubble or is captured while stalled. A wrong stall term shows at the ports in the same cycle as the load sits in execute, and it also shifts every later select by one slot. The bench runs a cycle model of the pipeline next to the block and compares all four outputs on every cycle. Because of this, one bad decision is flagged in the cycle it happens and is not left to spread.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hazard_src_pipe.sv
// Decode-to-execute copy of the source numbers; a bubble enters as register 0.
module hazard_src_pipe #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bubble_i,
  input  logic [NSRC-1:0][AW-1:0]   id_src_i,
  output logic [NSRC-1:0][AW-1:0]   ex_src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ex_src_o <= '0;
    else if (bubble_i) ex_src_o <= '0;
    else               ex_src_o <= id_src_i;
  end
endmodule

// File: rtl/hazard_fwd_sel.sv
module hazard_fwd_sel
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output fwd_sel_e      sel_o
);
  logic src_live, mem_hit, wb_hit;

  assign src_live = (src_i != '0);
  assign mem_hit  = src_live && mem_we_i && (mem_rd_i == src_i);
  assign wb_hit   = src_live && wb_we_i  && (wb_rd_i  == src_i);

  // newer stage first
  always_comb begin
    if (mem_hit)     sel_o = SEL_MEM;
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end
endmodule

// File: rtl/hazard_load_interlock.sv
module hazard_load_interlock #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] id_src_i,
  input  logic [AW-1:0]           ex_rd_i,
  input  logic                    ex_we_i,
  input  logic                    ex_load_i,
  output logic                    stall_o
);
  logic [NSRC-1:0] hit;
  logic            load_live;

  assign load_live = ex_load_i && ex_we_i && (ex_rd_i != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign hit[g] = load_live && (id_src_i[g] == ex_rd_i);
  end

  assign stall_o = |hit;
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] id_rs1_i,
  input  logic [AW-1:0] id_rs2_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_we_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          stall_o,
  output logic          bubble_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] id_src, ex_src;
  fwd_sel_e                sel [NSRC];
  logic                    stall;

  assign id_src[0] = id_rs1_i;
  assign id_src[1] = id_rs2_i;

  hazard_load_interlock #(.AW(AW), .NSRC(NSRC)) u_interlock (
    .id_src_i  (id_src),
    .ex_rd_i   (ex_rd_i),
    .ex_we_i   (ex_we_i),
    .ex_load_i (ex_load_i),
    .stall_o   (stall)
  );

  hazard_src_pipe #(.AW(AW), .NSRC(NSRC)) u_src_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bubble_i (stall),
    .id_src_i (id_src),
    .ex_src_o (ex_src)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_sel
    hazard_fwd_sel #(.AW(AW)) u_sel (
      .src_i    (ex_src[g]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel[g])
    );
  end

  assign fwd_a_o  = sel[0];
  assign fwd_b_o  = sel[1];
  assign stall_o  = stall;
  assign bubble_o = stall;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] id_rs1_i,
  input logic [AW-1:0] id_rs2_i,
  input logic [AW-1:0] ex_rd_i,
  input logic          ex_we_i,
  input logic          ex_load_i,
  input logic [AW-1:0] mem_rd_i,
  input logic          mem_we_i,
  input logic [1:0]    fwd_a_o,
  input logic [1:0]    fwd_b_o,
  input logic          stall_o
);
  // R8: the bubble reaches execute with no bypass
  a_r8_bubble_no_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

  // R6: register 0 never bypasses
  a_r6_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs1_i == '0 && !stall_o) |=> (fwd_a_o == 2'b00));

  // R9: only loads stall
  a_r9_stall_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_load_i |-> !stall_o);

  // R10: disabled writes never stall
  a_r10_stall_needs_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_we_i |-> !stall_o);

  // R2: memory-stage writer of the operand wins the bypass
  a_r2_mem_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && id_rs2_i != '0) |=>
      (!mem_we_i || mem_rd_i != $past(id_rs2_i) || fwd_b_o == 2'b01));

  // R7: a matching live load always stalls
  a_r7_load_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_load_i && ex_we_i && ex_rd_i != '0 && ex_rd_i == id_rs1_i) |-> stall_o);
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .id_rs1_i  (id_rs1_i),
  .id_rs2_i  (id_rs2_i),
  .ex_rd_i   (ex_rd_i),
  .ex_we_i   (ex_we_i),
  .ex_load_i (ex_load_i),
  .mem_rd_i  (mem_rd_i),
  .mem_we_i  (mem_we_i),
  .fwd_a_o   (fwd_a_o),
  .fwd_b_o   (fwd_b_o),
  .stall_o   (stall_o)
);

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;
  localparam int AW = 5;

  typedef struct packed {
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
    logic [AW-1:0] rd;
    logic          we;
    logic          ld;
  } ins_t;

  localparam ins_t NOP = '0;

  logic clk_i = 1'b0;
  logic rst_ni;
  always #5 clk_i = ~clk_i;

  ins_t dec_s, ex_s, mem_s, wb_s;
  logic [1:0] fwd_a_o, fwd_b_o;
  logic stall_o, bubble_o;
  int vectors = 0, errors = 0;
  logic last_stall = 1'b0, prev_stall = 1'b0;

  hazard_ctrl #(.AW(AW)) u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_rs1_i  (dec_s.rs1),
    .id_rs2_i  (dec_s.rs2),
    .ex_rd_i   (ex_s.rd),
    .ex_we_i   (ex_s.we),
    .ex_load_i (ex_s.ld),
    .mem_rd_i  (mem_s.rd),
    .mem_we_i  (mem_s.we),
    .wb_rd_i   (wb_s.rd),
    .wb_we_i   (wb_s.we),
    .fwd_a_o   (fwd_a_o),
    .fwd_b_o   (fwd_b_o),
    .stall_o   (stall_o),
    .bubble_o  (bubble_o)
  );

  function automatic logic [1:0] exp_sel(logic [AW-1:0] src);
    if (src != '0 && mem_s.we && mem_s.rd == src) return 2'b01;
    if (src != '0 && wb_s.we && wb_s.rd == src) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    return ex_s.ld && ex_s.we && ex_s.rd != '0 &&
           (ex_s.rd == dec_s.rs1 || ex_s.rd == dec_s.rs2);
  endfunction

  function automatic string sel_tag(logic [AW-1:0] src);
    logic mh, wh;
    if (prev_stall) return "R8";
    if (src == '0) return "R6";
    mh = mem_s.we && mem_s.rd == src;
    wh = wb_s.we && wb_s.rd == src;
    if (mh && wh) return "R4";
    if (mh) return "R2";
    if (wh) return "R3";
    if (mem_s.rd == src || wb_s.rd == src) return "R10";
    return "R5";
  endfunction

  task automatic chk(string tag, logic [1:0] got, logic [1:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    logic es;
    string st;
    #1;
    es = exp_stall();
    st = es ? "R7" : (ex_s.ld ? "R9" : "R10");
    chk(st, {1'b0, stall_o}, {1'b0, es});
    chk(st, {1'b0, bubble_o}, {1'b0, es});
    chk(sel_tag(ex_s.rs1), fwd_a_o, exp_sel(ex_s.rs1));
    chk(sel_tag(ex_s.rs2), fwd_b_o, exp_sel(ex_s.rs2));
    last_stall = es;
    @(posedge clk_i);
    #1;
    wb_s  = mem_s;
    mem_s = ex_s;
    ex_s  = es ? NOP : dec_s;
    @(negedge clk_i);
    prev_stall = es;
  endtask

  task automatic issue(logic [AW-1:0] rs1, logic [AW-1:0] rs2,
                       logic [AW-1:0] rd, logic we, logic ld);
    dec_s = '{rs1: rs1, rs2: rs2, rd: rd, we: we, ld: ld};
    do step(); while (last_stall);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) issue(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    dec_s = NOP; ex_s = NOP; mem_s = NOP; wb_s = NOP;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1 in reset
    chk("R1", fwd_a_o, 2'b00);
    chk("R1", fwd_b_o, 2'b00);
    chk("R1", {1'b0, stall_o}, 2'b00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", fwd_a_o, 2'b00);

    issue(0, 0, 1, 1, 0); issue(1, 0, 9, 1, 0); step();          // R2
    drain();
    issue(0, 0, 2, 1, 0); issue(0, 0, 9, 1, 0); issue(0, 2, 0, 0, 0); step(); // R3
    drain();
    issue(0, 0, 3, 1, 0); issue(0, 0, 3, 1, 0); issue(3, 0, 0, 0, 0); step(); // R4
    drain();
    issue(0, 0, 4, 1, 0); issue(0, 0, 0, 0, 0); issue(0, 0, 0, 0, 0);
    issue(4, 0, 0, 0, 0); step();                                  // R5
    drain();
    issue(0, 0, 0, 1, 1); issue(0, 0, 0, 0, 0); step();            // R6
    drain();
    issue(0, 0, 5, 1, 1); issue(5, 0, 0, 0, 0); step(); step();    // R7, R8
    drain();
    issue(0, 0, 6, 1, 1); issue(7, 7, 0, 0, 0); step();            // R9
    drain();
    issue(0, 0, 8, 0, 0); issue(8, 8, 0, 0, 0); step();            // R10
    issue(0, 0, 8, 0, 1); issue(8, 0, 0, 0, 0); step();
    drain();

    void'($urandom(32'd1611));
    for (int n = 0; n < 3000; n++) begin
      logic ld;
      ld = ($urandom % 4) == 0;
      issue(AW'($urandom % 4), AW'($urandom % 4), AW'($urandom % 4),
            ld || ($urandom % 4 != 0), ld);
    end
    drain();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule